// File: doc/BRIEF.md
# Power-On Strap Sampling Sequencer

This block runs the start-up sequence of six pins that each serve two purposes. Right after the supply becomes valid, each pin acts as a configuration input. Its level is set by an external pull resistor to ground or to the supply. After a fixed sampling window, each level is frozen into a configuration bit. Only then are the pin drivers switched on, and from that point each pin carries a clock.

The supply-valid indication `pwr_good_i` is the only thing that can clear the block. While it is low, the sequencer sits in state WAIT_POWER with all drivers off and the configuration word cleared.

The sequence has three states and three transitions:
- WAIT_POWER to SAMPLE on the first reference clock edge after `pwr_good_i` goes high.
- SAMPLE to RUN when the window counter reaches its last count.
- Any state back to WAIT_POWER when `pwr_good_i` falls.

In RUN, each pin is driven by its clock source through a glitch-free gate. The gate opens only while that source is low, so the first pulse on the pin is always a full pulse.

Top module: `strap_seq_top`

## Requirements
- R1: `pin_oe_o` is all zeros in WAIT_POWER and SAMPLE, so all six drivers are tristated and the pulls set the pin levels.
- R2: While `pwr_good_i` is low, the block is held in WAIT_POWER with `strap_cfg_o`, `cfg_valid_o`, `pin_oe_o` and `pin_drv_o` all zero. This takes effect without waiting for a clock edge.
- R3: The first rising edge of `clk_ref_i` with `pwr_good_i` high moves WAIT_POWER to SAMPLE. SAMPLE then lasts exactly `WINDOW_CYCLES` clock edges, so `cfg_valid_o` rises on edge `WINDOW_CYCLES`+1 counted from the power-good rise.
- R4: Each pin input passes through a two-flop synchronizer. Bit k of `strap_cfg_o` receives the level that pin k had at the edge two before the final SAMPLE edge, that is, edge `WINDOW_CYCLES`-1. A low level gives 0 and a high level gives 1.
- R5: On the final SAMPLE edge, the block enters RUN. From that edge, `pin_oe_o` is all ones and `cfg_valid_o` is 1, and never before the configuration has been latched.
- R6: Once latched, `strap_cfg_o` ignores any further change on `pin_in_i` for as long as `pwr_good_i` stays high.
- R7: `cfg_valid_o` stays high from its rise until `pwr_good_i` drops.
- R8: For each pin k, `pin_drv_o[k]` equals `clk_src_i[k]` AND a gate bit. The gate bit follows the run state only while `clk_src_i[k]` is low. `pin_drv_o[k]` is therefore 0 outside RUN and never starts with a shortened high phase.
- R9: A later rise of `pwr_good_i` restarts the whole sequence with a fresh sample of the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock that times the sampling window |
| pwr_good_i | input | 1 | Supply valid; low clears the block asynchronously |
| pin_in_i | input | 6 | Levels read back from the six pins |
| clk_src_i | input | 6 | Clock source for each pin |
| pin_oe_o | output | 6 | Driver enable per pin, 1 means drive |
| pin_drv_o | output | 6 | Value driven onto each pin |
| strap_cfg_o | output | 6 | Latched configuration word, bit k from pin k |
| cfg_valid_o | output | 1 | High while the configuration is latched and the drivers are on |

## Verification
The assertions are disabled while `pwr_good_i` is low. They take for granted that `pwr_good_i` changes away from the rising edge of `clk_ref_i`, and that `WINDOW_CYCLES` is at least 4, so the synchronizer is full before capture. The stimulus changes power-good, the pin levels and the clock sources only on falling reference edges. It keeps the window short, and it drops power-good in WAIT_POWER, mid-window and in RUN. It also changes the pins on every cycle of one window, so an off-by-one error in the capture edge produces a different word.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

    localparam int STRAP_PINS = 6;

    typedef enum logic [1:0] {
        ST_WAIT_POWER = 2'd0,
        ST_SAMPLE     = 2'd1,
        ST_RUN        = 2'd2
    } seq_state_e;

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_n_i) begin
                if (!rst_n_i) begin
                    chain_q[s] <= '0;
                end else begin
                    if (s == 0) begin
                        chain_q[s] <= async_i;
                    end else begin
                        chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
                    end
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/strap_window_fsm.sv
module strap_window_fsm
    import strap_seq_pkg::*;
#(
    parameter int WIDTH         = 6,
    parameter int WINDOW_CYCLES = 250000
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] cfg_o,
    output logic             run_o
);

    localparam int CNT_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WINDOW_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] win_cnt_q;
    logic [WIDTH-1:0] cfg_q;
    logic             window_end;

    assign window_end = (state_q == ST_SAMPLE) && (win_cnt_q == LAST_CNT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_POWER: state_d = ST_SAMPLE;
            ST_SAMPLE:     if (window_end) state_d = ST_RUN;
            ST_RUN:        state_d = ST_RUN;
            default:       state_d = ST_WAIT_POWER;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= ST_WAIT_POWER;
        end else begin
            state_q <= state_d;
        end
    end

    // window counter and strap capture
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            win_cnt_q <= '0;
            cfg_q     <= '0;
        end else begin
            if (state_q == ST_SAMPLE && !window_end) begin
                win_cnt_q <= win_cnt_q + 1'b1;
            end
            if (window_end) begin
                cfg_q <= level_i;
            end
        end
    end

    // outputs
    always_comb begin
        run_o = 1'b0;
        unique case (state_q)
            ST_WAIT_POWER: run_o = 1'b0;
            ST_SAMPLE:     run_o = 1'b0;
            ST_RUN:        run_o = 1'b1;
            default:       run_o = 1'b0;
        endcase
        cfg_o = cfg_q;
    end

endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
    input  logic rst_n_i,
    input  logic clk_in_i,
    input  logic en_i,
    output logic clk_out_o
);

    logic gate_q;

    // transparent only while the source clock is low
    always_latch begin
        if (!rst_n_i) begin
            gate_q <= 1'b0;
        end else if (!clk_in_i) begin
            gate_q <= en_i;
        end
    end

    assign clk_out_o = clk_in_i & gate_q;

endmodule

// File: rtl/strap_seq_top.sv
module strap_seq_top
    import strap_seq_pkg::*;
#(
    parameter int NUM_PINS      = STRAP_PINS,
    parameter int WINDOW_CYCLES = 250000
) (
    input  logic                clk_ref_i,
    input  logic                pwr_good_i,
    input  logic [NUM_PINS-1:0] pin_in_i,
    input  logic [NUM_PINS-1:0] clk_src_i,
    output logic [NUM_PINS-1:0] pin_oe_o,
    output logic [NUM_PINS-1:0] pin_drv_o,
    output logic [NUM_PINS-1:0] strap_cfg_o,
    output logic                cfg_valid_o
);

    logic [NUM_PINS-1:0] level_sync;
    logic [NUM_PINS-1:0] cfg_word;
    logic                run_state;

    strap_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (2)
    ) u_sync (
        .clk_i   (clk_ref_i),
        .rst_n_i (pwr_good_i),
        .async_i (pin_in_i),
        .sync_o  (level_sync)
    );

    strap_window_fsm #(
        .WIDTH         (NUM_PINS),
        .WINDOW_CYCLES (WINDOW_CYCLES)
    ) u_fsm (
        .clk_i   (clk_ref_i),
        .rst_n_i (pwr_good_i),
        .level_i (level_sync),
        .cfg_o   (cfg_word),
        .run_o   (run_state)
    );

    generate
        for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
            clk_gate_cell u_gate (
                .rst_n_i   (pwr_good_i),
                .clk_in_i  (clk_src_i[k]),
                .en_i      (run_state),
                .clk_out_o (pin_drv_o[k])
            );
        end
    endgenerate

    always_comb begin
        pin_oe_o    = {NUM_PINS{run_state}};
        cfg_valid_o = run_state;
        strap_cfg_o = cfg_word;
    end

endmodule

// File: rtl/strap_seq_checker.sv
module strap_seq_checker #(
    parameter int NUM_PINS      = 6,
    parameter int WINDOW_CYCLES = 250000
) (
    input logic                clk_ref_i,
    input logic                pwr_good_i,
    input logic [NUM_PINS-1:0] pin_oe_o,
    input logic [NUM_PINS-1:0] pin_drv_o,
    input logic [NUM_PINS-1:0] strap_cfg_o,
    input logic                cfg_valid_o
);

    int unsigned edges_q;

    // edges seen since power-good rose, saturating
    always_ff @(posedge clk_ref_i or negedge pwr_good_i) begin
        if (!pwr_good_i) begin
            edges_q <= 0;
        end else if (edges_q < WINDOW_CYCLES + 2) begin
            edges_q <= edges_q + 1;
        end
    end

    assert_tristate_R1: assert property (@(posedge clk_ref_i) disable iff (!pwr_good_i)
        !cfg_valid_o |-> (pin_oe_o == '0));

    assert_cleared_R2: assert property (@(posedge clk_ref_i) disable iff (!pwr_good_i)
        !cfg_valid_o |-> (strap_cfg_o == '0));

    assert_window_len_R3: assert property (@(posedge clk_ref_i) disable iff (!pwr_good_i)
        $rose(cfg_valid_o) |-> (edges_q == WINDOW_CYCLES + 1));

    assert_drivers_on_R5: assert property (@(posedge clk_ref_i) disable iff (!pwr_good_i)
        cfg_valid_o |-> (pin_oe_o == {NUM_PINS{1'b1}}));

    assert_cfg_frozen_R6: assert property (@(posedge clk_ref_i) disable iff (!pwr_good_i)
        (cfg_valid_o && $past(cfg_valid_o)) |-> $stable(strap_cfg_o));

    assert_valid_held_R7: assert property (@(posedge clk_ref_i) disable iff (!pwr_good_i)
        cfg_valid_o |=> cfg_valid_o);

    assert_drv_quiet_R8: assert property (@(posedge clk_ref_i) disable iff (!pwr_good_i)
        !cfg_valid_o |-> (pin_drv_o == '0));

endmodule

bind strap_seq_top strap_seq_checker #(
    .NUM_PINS      (NUM_PINS),
    .WINDOW_CYCLES (WINDOW_CYCLES)
) u_chk (
    .clk_ref_i   (clk_ref_i),
    .pwr_good_i  (pwr_good_i),
    .pin_oe_o    (pin_oe_o),
    .pin_drv_o   (pin_drv_o),
    .strap_cfg_o (strap_cfg_o),
    .cfg_valid_o (cfg_valid_o)
);

// File: tb/sim_strap_seq_top.sv
`timescale 1ns/1ps
module sim_strap_seq_top;

    localparam int N   = 6;
    localparam int WIN = 12;

    logic         clk = 1'b0;
    logic         pg;
    logic [N-1:0] pins;
    logic [N-1:0] srcs;
    logic [N-1:0] oe, drv, cfg;
    logic         valid;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // reference model state
    int           m_edges;
    logic [N-1:0] m_hist[$];
    logic [N-1:0] m_cap;
    logic [N-1:0] m_gate;
    int           div_cnt [N];

    always #4 clk = ~clk;  // 125 MHz

    strap_seq_top #(
        .NUM_PINS      (N),
        .WINDOW_CYCLES (WIN)
    ) u0 (
        .clk_ref_i   (clk),
        .pwr_good_i  (pg),
        .pin_in_i    (pins),
        .clk_src_i   (srcs),
        .pin_oe_o    (oe),
        .pin_drv_o   (drv),
        .strap_cfg_o (cfg),
        .cfg_valid_o (valid)
    );

    function automatic bit m_valid();
        return m_edges >= WIN + 1;
    endfunction

    task automatic model_clear();
        m_edges = 0;
        m_hist.delete();
        m_cap  = '0;
        m_gate = '0;
    endtask

    task automatic model_gate();
        for (int k = 0; k < N; k++) begin
            if (!pg) m_gate[k] = 1'b0;
            else if (!srcs[k]) m_gate[k] = m_valid();
        end
    endtask

    task automatic check(input string req, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
        end
    endtask

    // clock sources: pin k toggles every k+1 reference cycles, on falling edges
    initial begin
        srcs = '0;
        for (int k = 0; k < N; k++) div_cnt[k] = 0;
    end
    always @(negedge clk) begin
        for (int k = 0; k < N; k++) begin
            div_cnt[k]++;
            if (div_cnt[k] > k) begin
                div_cnt[k] = 0;
                srcs[k] = ~srcs[k];
            end
        end
    end

    // model update just after each rising edge
    always @(posedge clk) begin
        #1;
        if (!pg) begin
            model_clear();
        end else begin
            if (m_edges < WIN + 2) m_edges++;
            if (m_edges <= WIN + 1) m_hist.push_back(pins);
            if (m_edges == WIN + 1) m_cap = m_hist[WIN-2];  // R4: level at edge WIN-1
        end
        model_gate();
    end

    // compare between edges
    always @(negedge clk) begin
        #2;
        if (!pg) model_clear();
        model_gate();
        if (!done) begin
            // R1 / R5 / R2: drivers off until latched
            check(pg ? "R1/R5" : "R2", "pin_oe", oe, m_valid() ? '1 : '0);
            // R7 / R3 / R2: valid flag timing
            check(pg ? "R3/R7" : "R2", "cfg_valid", N'(valid), N'(m_valid()));
            // R4 / R6 / R9: latched word
            check(pg ? "R4/R6/R9" : "R2", "strap_cfg", cfg, m_valid() ? m_cap : '0);
            // R8: gated clock, no runt
            check("R8", "pin_drv", drv, srcs & m_gate);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        pg   = 1'b0;
        pins = 6'b101101;
        idle(4);                                 // R2 reset state
        pg = 1'b1;                               // R3 start window
        idle(WIN + 8);
        pins = 6'b010010; idle(3);               // R6 ignored after latch
        pins = 6'b111111; idle(10);
        pg = 1'b0; idle(3);                      // R2 drop in RUN
        pins = 6'b000000;
        pg = 1'b1; idle(5);                      // R9 restart
        pg = 1'b0; idle(2);                      // drop mid-window
        pins = 6'b110011;
        pg = 1'b1; idle(WIN + 10);               // R4 fresh capture
        pg = 1'b0; idle(2);
        pg = 1'b1;                               // R4 pins move every cycle
        for (int i = 0; i < WIN + 6; i++) begin
            pins = 6'(i * 5 + 3);
            idle(1);
        end
        idle(12);
        pg = 1'b0; idle(3);
        pins = 6'b111111;
        pg = 1'b1; idle(WIN + 20);               // R8 all-high straps, run gates
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20000 * 8);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule